// File: doc/BRIEF.md
# Per-Source Event State Gate

The gate keeps a two-bit coalescing state for each of a fixed number of interrupt sources. It decides whether a trigger from a source becomes an event notification towards the routing stage. The first bit (P) marks that a notification is outstanding and the second bit (Q) marks that a further trigger arrived while one was outstanding. A trigger that finds the source idle is forwarded. A trigger that finds it busy is folded into the Q bit, and a source parked in the masked state swallows triggers.

Software reaches every source through a small register port. It can read a source's state, overwrite it (mask or unmask), or perform end-of-interrupt on that source. Every access returns the state the source held before the access. An end-of-interrupt on a source that collected a queued trigger re-arms it at once and sends a fresh notification. Notifications leave on a valid/ready port carrying the source number. A one-entry holding slot stalls both input ports while the consumer is not ready, so no event is dropped.

Top module: `esg_gate`

## Requirements
- R1: After reset every source state is 00, `ntf_valid_o` and `mmio_rvalid_o` are low and both ready outputs are high.
- R2: An accepted trigger to a source in state 00 moves it to 10, and in the next cycle `ntf_valid_o` is high with `ntf_src_o` equal to the source number.
- R3: An accepted trigger to a source in state 10 or 11 moves it to 11 and produces no notification.
- R4: An accepted trigger to a source in state 01 (masked) leaves the state at 01 and produces no notification.
- R5: An accepted register access with op code 0 (or 3) reads the addressed source: one cycle later `mmio_rvalid_o` is high and `mmio_rdata_o` holds {P,Q}, with P in bit 1 and Q in bit 0, and the state is unchanged.
- R6: Op code 1 writes `mmio_wdata_i` (P in bit 1, Q in bit 0) into the addressed source and returns the old value; it never produces a notification.
- R7: Op code 2 (end-of-interrupt) returns the old value. If Q was 0 the state becomes 00 with no notification; if Q was 1 the state becomes 10 and a notification for that source follows in the next cycle.
- R8: When a trigger and a register access address the same source in one cycle, the access is applied first and the trigger is judged against the state the access left.
- R9: While `ntf_valid_o` is high and `ntf_ready_i` is low, the notification and its source number are held, and both `trig_ready_o` and `mmio_ready_o` are low; the held event is delivered once ready rises.
- R10: When an accepted end-of-interrupt forwards a notification, a trigger to a different source in the same cycle is refused (`trig_ready_o` low) and leaves that source's state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid_i | input | 1 | Trigger pulse present |
| trig_src_i | input | SRC_W | Source raising the trigger |
| trig_ready_o | output | 1 | Trigger accepted this cycle |
| mmio_req_i | input | 1 | Register access request |
| mmio_op_i | input | 2 | 0/3 read, 1 set state, 2 end-of-interrupt |
| mmio_src_i | input | SRC_W | Addressed source |
| mmio_wdata_i | input | 2 | New state for op 1, {P,Q} |
| mmio_ready_o | output | 1 | Access accepted this cycle |
| mmio_rvalid_o | output | 1 | Response valid, one cycle after acceptance |
| mmio_rdata_o | output | 2 | State before the access, {P,Q} |
| ntf_valid_o | output | 1 | Notification pending |
| ntf_src_o | output | SRC_W | Source number of the notification |
| ntf_ready_i | input | 1 | Consumer takes the notification |

## Verification
A trigger and a register access can land in the same cycle, either on the same source, where ordering decides the outcome, or on different sources, where an end-of-interrupt and a trigger could both want the one notification slot. The bench provokes the first case by pairing a trigger with every op code on one source in each of the four starting states, and the second by an end-of-interrupt on a queued source alongside a trigger to an idle one. Each outcome is judged by the accept signals in that cycle, the returned old value, the notification one cycle later and a follow-up read of both sources.

// File: rtl/esg_pkg.sv
package esg_pkg;

    typedef enum logic [1:0] {
        ESG_READ     = 2'd0,
        ESG_SETPQ    = 2'd1,
        ESG_EOI      = 2'd2,
        ESG_READ_ALT = 2'd3
    } esg_op_e;

    localparam logic [1:0] PQ_IDLE   = 2'b00;
    localparam logic [1:0] PQ_MASKED = 2'b01;
    localparam logic [1:0] PQ_PEND   = 2'b10;
    localparam logic [1:0] PQ_QUEUED = 2'b11;

    // Result bit 2 is the forward flag, bits 1:0 the new state.
    function automatic logic [2:0] trig_step(input logic [1:0] pq);
        case (pq)
            PQ_IDLE:   trig_step = {1'b1, PQ_PEND};
            PQ_MASKED: trig_step = {1'b0, PQ_MASKED};
            default:   trig_step = {1'b0, PQ_QUEUED};
        endcase
    endfunction

    function automatic logic [2:0] eoi_step(input logic [1:0] pq);
        if (pq[0]) eoi_step = {1'b1, PQ_PEND};
        else       eoi_step = {1'b0, PQ_IDLE};
    endfunction

endpackage

// File: rtl/esg_state_array.sv
module esg_state_array
    import esg_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mmio_en,
    input  esg_op_e                   mmio_op,
    input  logic [SRC_W-1:0]          mmio_src,
    input  logic [1:0]                mmio_wdata,
    input  logic                      trig_en,
    input  logic [SRC_W-1:0]          trig_src,
    output logic [1:0]                mmio_old_o,
    output logic                      eoi_peek_o,
    output logic                      eoi_fwd_o,
    output logic                      trig_fwd_o,
    output logic [NUM_SRC-1:0][1:0]   pq_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0][1:0] pq;
    } arr_t;

    arr_t st_q, st_d;
    logic [NUM_SRC-1:0][1:0] mid_pq;

    // Whether an end-of-interrupt at this address would re-forward.
    assign eoi_peek_o = (mmio_op == ESG_EOI) && st_q.pq[mmio_src][0];

    always_comb begin
        logic [2:0] res;
        mid_pq     = st_q.pq;
        mmio_old_o = st_q.pq[mmio_src];
        eoi_fwd_o  = 1'b0;
        trig_fwd_o = 1'b0;
        res        = '0;
        // Register access first.
        if (mmio_en) begin
            case (mmio_op)
                ESG_SETPQ: mid_pq[mmio_src] = mmio_wdata;
                ESG_EOI: begin
                    res               = eoi_step(st_q.pq[mmio_src]);
                    eoi_fwd_o         = res[2];
                    mid_pq[mmio_src]  = res[1:0];
                end
                default: ;
            endcase
        end
        st_d.pq = mid_pq;
        // Trigger judged against the post-access state.
        if (trig_en) begin
            res               = trig_step(mid_pq[trig_src]);
            trig_fwd_o        = res[2];
            st_d.pq[trig_src] = res[1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pq_o = st_q.pq;

endmodule

// File: rtl/esg_ntf_slot.sv
module esg_ntf_slot #(
    parameter int SRC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [SRC_W-1:0] push_src_i,
    input  logic             ready_i,
    output logic             valid_o,
    output logic [SRC_W-1:0] src_o,
    output logic             free_o
);

    typedef struct packed {
        logic             valid;
        logic [SRC_W-1:0] src;
    } slot_t;

    slot_t slot_q, slot_d;

    assign free_o = !slot_q.valid || ready_i;

    always_comb begin
        slot_d = slot_q;
        if (free_o) begin
            slot_d.valid = push_i;
            if (push_i) slot_d.src = push_src_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign valid_o = slot_q.valid;
    assign src_o   = slot_q.src;

endmodule

// File: rtl/esg_gate.sv
module esg_gate
    import esg_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_valid_i,
    input  logic [SRC_W-1:0] trig_src_i,
    output logic             trig_ready_o,
    input  logic             mmio_req_i,
    input  logic [1:0]       mmio_op_i,
    input  logic [SRC_W-1:0] mmio_src_i,
    input  logic [1:0]       mmio_wdata_i,
    output logic             mmio_ready_o,
    output logic             mmio_rvalid_o,
    output logic [1:0]       mmio_rdata_o,
    output logic             ntf_valid_o,
    output logic [SRC_W-1:0] ntf_src_o,
    input  logic             ntf_ready_i
);

    typedef struct packed {
        logic       rvalid;
        logic [1:0] rdata;
    } rsp_t;

    rsp_t rsp_q, rsp_d;

    logic                    slot_free;
    logic                    mmio_en;
    logic                    trig_en;
    logic                    eoi_peek;
    logic                    eoi_fwd;
    logic                    trig_fwd;
    logic [1:0]              mmio_old;
    logic                    push;
    logic [SRC_W-1:0]        push_src;
    logic [NUM_SRC-1:0][1:0] pq_vec;

    assign mmio_ready_o = slot_free;
    assign mmio_en      = mmio_req_i && slot_free;
    // Refuse a trigger that could compete with a re-forwarding EOI.
    assign trig_ready_o = slot_free &&
                          !(mmio_en && eoi_peek && (trig_src_i != mmio_src_i));
    assign trig_en      = trig_valid_i && trig_ready_o;

    esg_state_array #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_arr (
        .clk        (clk),
        .rst_n      (rst_n),
        .mmio_en    (mmio_en),
        .mmio_op    (esg_op_e'(mmio_op_i)),
        .mmio_src   (mmio_src_i),
        .mmio_wdata (mmio_wdata_i),
        .trig_en    (trig_en),
        .trig_src   (trig_src_i),
        .mmio_old_o (mmio_old),
        .eoi_peek_o (eoi_peek),
        .eoi_fwd_o  (eoi_fwd),
        .trig_fwd_o (trig_fwd),
        .pq_o       (pq_vec)
    );

    assign push     = eoi_fwd || trig_fwd;
    assign push_src = eoi_fwd ? mmio_src_i : trig_src_i;

    esg_ntf_slot #(.SRC_W(SRC_W)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push),
        .push_src_i (push_src),
        .ready_i    (ntf_ready_i),
        .valid_o    (ntf_valid_o),
        .src_o      (ntf_src_o),
        .free_o     (slot_free)
    );

    always_comb begin
        rsp_d.rvalid = mmio_en;
        rsp_d.rdata  = mmio_en ? mmio_old : rsp_q.rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign mmio_rvalid_o = rsp_q.rvalid;
    assign mmio_rdata_o  = rsp_q.rdata;

endmodule

// File: rtl/esg_gate_chk.sv
module esg_gate_chk #(
    parameter int NUM_SRC = 8,
    parameter int SRC_W   = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    trig_valid_i,
    input logic [SRC_W-1:0]        trig_src_i,
    input logic                    trig_ready_o,
    input logic                    mmio_req_i,
    input logic                    mmio_ready_o,
    input logic                    mmio_rvalid_o,
    input logic                    ntf_valid_o,
    input logic [SRC_W-1:0]        ntf_src_o,
    input logic                    ntf_ready_i,
    input logic                    eoi_fwd,
    input logic                    trig_fwd,
    input logic [NUM_SRC-1:0][1:0] pq_vec
);

    logic trig_acc, mmio_acc;
    assign trig_acc = trig_valid_i && trig_ready_o;
    assign mmio_acc = mmio_req_i && mmio_ready_o;

    // R9
    held_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ntf_valid_o && !ntf_ready_i |=> ntf_valid_o && $stable(ntf_src_o));

    // R9
    stall_bp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ntf_valid_o && !ntf_ready_i |-> !trig_ready_o && !mmio_ready_o);

    // R5
    rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mmio_acc |=> mmio_rvalid_o);

    // R5
    no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mmio_acc |=> !mmio_rvalid_o);

    // R4
    masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_acc && !mmio_acc && pq_vec[trig_src_i] == 2'b01 |=> !ntf_valid_o);

    // R2
    fwd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_acc && !mmio_acc && pq_vec[trig_src_i] == 2'b00
        |=> ntf_valid_o && ntf_src_o == $past(trig_src_i));

    // R10
    single_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_fwd |-> !trig_fwd);

endmodule

bind esg_gate esg_gate_chk #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .trig_valid_i  (trig_valid_i),
    .trig_src_i    (trig_src_i),
    .trig_ready_o  (trig_ready_o),
    .mmio_req_i    (mmio_req_i),
    .mmio_ready_o  (mmio_ready_o),
    .mmio_rvalid_o (mmio_rvalid_o),
    .ntf_valid_o   (ntf_valid_o),
    .ntf_src_o     (ntf_src_o),
    .ntf_ready_i   (ntf_ready_i),
    .eoi_fwd       (eoi_fwd),
    .trig_fwd      (trig_fwd),
    .pq_vec        (pq_vec)
);

// File: tb/tb_esg_gate.sv
`timescale 1ns/100ps
module tb_esg_gate;

    localparam int N  = 8;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          trig_valid;
    logic [SW-1:0] trig_src;
    logic          trig_ready;
    logic          mmio_req;
    logic [1:0]    mmio_op;
    logic [SW-1:0] mmio_src;
    logic [1:0]    mmio_wdata;
    logic          mmio_ready;
    logic          mmio_rvalid;
    logic [1:0]    mmio_rdata;
    logic          ntf_valid;
    logic [SW-1:0] ntf_src;
    logic          ntf_ready;

    int errors = 0;
    int checks = 0;

    logic [1:0]    pq_m [N];
    logic          nv_m;
    logic [SW-1:0] ns_m;

    always #2.5 clk = ~clk;

    esg_gate #(.NUM_SRC(N)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .trig_valid_i  (trig_valid),
        .trig_src_i    (trig_src),
        .trig_ready_o  (trig_ready),
        .mmio_req_i    (mmio_req),
        .mmio_op_i     (mmio_op),
        .mmio_src_i    (mmio_src),
        .mmio_wdata_i  (mmio_wdata),
        .mmio_ready_o  (mmio_ready),
        .mmio_rvalid_o (mmio_rvalid),
        .mmio_rdata_o  (mmio_rdata),
        .ntf_valid_o   (ntf_valid),
        .ntf_src_o     (ntf_src),
        .ntf_ready_i   (ntf_ready)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at a falling edge, predict, sample at the next falling edge.
    task automatic cyc(input string tag, input logic tv, input int ts, input logic mr,
                       input int op, input int ms, input int wd, input logic nr);
        logic free, mem, peek, tacc, efwd, tfwd, etr, emr;
        logic [1:0] old;
        trig_valid = tv;  trig_src = ts[SW-1:0];
        mmio_req = mr;    mmio_op = op[1:0];
        mmio_src = ms[SW-1:0]; mmio_wdata = wd[1:0];
        ntf_ready = nr;
        #1;
        free = !nv_m || nr;
        mem  = mr && free;
        peek = (op == 2) && pq_m[ms][0];
        etr  = free && !(mem && peek && ts != ms);
        emr  = free;
        chk(tag, "trig_ready", int'(trig_ready), int'(etr));
        chk(tag, "mmio_ready", int'(mmio_ready), int'(emr));
        tacc = tv && etr;
        old  = pq_m[ms];
        efwd = 1'b0;
        tfwd = 1'b0;
        if (mem) begin
            if (op == 1) pq_m[ms] = wd[1:0];
            else if (op == 2) begin
                if (old[0]) begin pq_m[ms] = 2'b10; efwd = 1'b1; end
                else pq_m[ms] = 2'b00;
            end
        end
        if (tacc) begin
            if (pq_m[ts] == 2'b00) begin pq_m[ts] = 2'b10; tfwd = 1'b1; end
            else if (pq_m[ts] != 2'b01) pq_m[ts] = 2'b11;
        end
        if (free) begin
            nv_m = efwd || tfwd;
            if (nv_m) ns_m = efwd ? ms[SW-1:0] : ts[SW-1:0];
        end
        @(posedge clk);
        @(negedge clk);
        chk(tag, "rvalid", int'(mmio_rvalid), int'(mem));
        if (mem) chk(tag, "rdata", int'(mmio_rdata), int'(old));
        chk(tag, "ntf_valid", int'(ntf_valid), int'(nv_m));
        if (nv_m) chk(tag, "ntf_src", int'(ntf_src), int'(ns_m));
    endtask

    task automatic set_pq(input string tag, input int s, input int v);
        cyc(tag, 1'b0, 0, 1'b1, 1, s, v, 1'b1);
    endtask

    task automatic rd(input string tag, input int s);
        cyc(tag, 1'b0, 0, 1'b1, 0, s, 0, 1'b1);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) pq_m[i] = 2'b00;
        nv_m = 1'b0; ns_m = '0;
        rst_n = 1'b0; trig_valid = 1'b0; trig_src = '0; mmio_req = 1'b0;
        mmio_op = 2'd0; mmio_src = '0; mmio_wdata = 2'd0; ntf_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1", "ntf_valid", int'(ntf_valid), 0);
        chk("R1", "rvalid", int'(mmio_rvalid), 0);
        chk("R1", "trig_ready", int'(trig_ready), 1);
        chk("R1", "mmio_ready", int'(mmio_ready), 1);
        for (int s = 0; s < N; s++) rd("R1", s);

        // R2 R3 R4 R6: trigger from each starting state on each source
        for (int s = 0; s < N; s++) begin
            for (int st = 0; st < 4; st++) begin
                set_pq("R6", s, st);
                cyc(st == 0 ? "R2" : (st == 1 ? "R4" : "R3"), 1'b1, s, 1'b0, 0, 0, 0, 1'b1);
                rd("R5", s);
            end
        end

        // R7: end-of-interrupt from each state, plus alternate read code
        for (int s = 0; s < N; s++) begin
            for (int st = 0; st < 4; st++) begin
                set_pq("R6", s, st);
                cyc("R7", 1'b0, 0, 1'b1, 2, s, 0, 1'b1);
                cyc("R5", 1'b0, 0, 1'b1, 3, s, 0, 1'b1);
            end
        end

        // R8: same-source collision of trigger with every op
        for (int st = 0; st < 4; st++) begin
            for (int op = 0; op < 3; op++) begin
                for (int wd = 0; wd < 4; wd++) begin
                    set_pq("R8", 5, st);
                    cyc("R8", 1'b1, 5, 1'b1, op, 5, wd, 1'b1);
                    rd("R8", 5);
                end
            end
        end

        // R9: stall holds the event and blocks both ports
        set_pq("R9", 1, 0);
        set_pq("R9", 2, 0);
        cyc("R9", 1'b1, 1, 1'b0, 0, 0, 0, 1'b0);
        for (int k = 0; k < 4; k++) cyc("R9", 1'b1, 2, 1'b1, 1, 2, 3, 1'b0);
        cyc("R9", 1'b1, 2, 1'b0, 0, 0, 0, 1'b1);
        rd("R9", 2);
        rd("R9", 1);

        // R10: re-forwarding EOI against a trigger on another source
        set_pq("R10", 3, 3);
        set_pq("R10", 4, 0);
        cyc("R10", 1'b1, 4, 1'b1, 2, 3, 0, 1'b1);
        rd("R10", 4);
        rd("R10", 3);
        cyc("R10", 1'b1, 4, 1'b0, 0, 0, 0, 1'b1);
        // EOI without Q does not block a trigger elsewhere
        set_pq("R10", 6, 2);
        set_pq("R10", 7, 0);
        cyc("R10", 1'b1, 7, 1'b1, 2, 6, 0, 1'b1);
        rd("R10", 6);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule